// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of general-purpose I/O pins behind a word-wide register interface. Software chooses per pin whether the block drives it or only watches it. It sets the driven value by a direct write, or it changes only chosen bits through separate set and clear addresses, so no read-modify-write is needed. Incoming pin levels pass through a two-stage synchronizer before the block reads them or uses them for detection.

Each pin has four independent trigger masks: low level, high level, rising edge and falling edge. Any mix of these can be enabled. Every trigger hit sets a sticky status bit. Software clears a status bit by writing a 1 to it. A separate enable mask, also changed through set and clear addresses, chooses which status bits reach the single combined interrupt line. Register accesses are single-cycle writes, and reads are combinational from the current address.

Internally the pin state has no sequential controller. The register decoder works as a selector: an enumerated register select moves from its idle value (`SEL_NONE`) to one of twelve named targets, based on the word address. A write acts on the selected target in the same clock. Unaligned or unmapped addresses fall back to `SEL_NONE`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every pin an input), `pin_drive_en` is 0, and the data-out register, all four trigger masks, the enable mask, the status register and `irq` are all 0.
- R2: `pin_drive_en[i]` is the inverse of direction bit i: a 1 in the direction register makes pin i an input, and a 0 makes it driven. `pin_out` always equals the data-out register.
- R3: Byte offsets (word-aligned, 8-bit address): 0x00 direction, 0x04 data-out, 0x08 data-out set, 0x0C data-out clear, 0x10 data-in, 0x14 low-level mask, 0x18 high-level mask, 0x1C rising mask, 0x20 falling mask, 0x24 status, 0x28 enable set, 0x2C enable clear. A write to 0x04 loads data-out. A write to 0x08 sets exactly the bits written as 1, a write to 0x0C clears exactly those bits, and bits written as 0 keep their value.
- R4: Reading 0x10 returns the pin levels through a two-flop synchronizer: a pin change driven before clock edge k first shows at data-in after edge k+1.
- R5: A pin whose low-level mask bit is set sets its status bit on every cycle its synchronized level is 0. A pin whose high-level mask bit is set does so on every cycle its level is 1. With both bits set, the status bit is set on every cycle.
- R6: The rising mask flags a 0-to-1 change and the falling mask flags a 1-to-0 change between consecutive synchronized samples. With both set, either change is flagged.
- R7: Status bits stay set until a write to 0x24 clears the bits written as 1. If a clear and a new hit on the same bit fall in the same cycle, the bit stays set.
- R8: A write to 0x28 sets the enable bits written as 1, and a write to 0x2C clears them. A read of either address returns the current enable mask.
- R9: `irq` is 1 exactly when some bit is set in both status and enable. Status bits are set even when their enable bit is 0.
- R10: Reads from an unmapped or unaligned address return 0. Writes to such addresses, or to the data-in address, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels, asynchronous to `clk` |
| pin_out | output | 32 | Output data for each pin |
| pin_drive_en | output | 32 | 1 where the block drives the pin |
| irq | output | 1 | Combined interrupt line |

## Verification
On every cycle, the embedded assertions check several properties. A status bit never drops without a status write. Active level hits and rising edges always show up in status one cycle later. A data-out clear leaves the written bits at zero. An enable-set write leaves the written bits set. Other properties appear only in bench scenarios: the synchronizer latency, the mixed trigger masks under random pin patterns, the same-cycle race between a clear and a new hit, the read-back of the enable mask at both addresses, and the behaviour on unmapped addresses.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int SEL_W    = 4;
    localparam int NUM_REGS = 12;

    // Word index of each register; byte offset is index * 4.
    typedef enum logic [SEL_W-1:0] {
        SEL_DIR       = 4'd0,
        SEL_DOUT      = 4'd1,
        SEL_DOUT_SET  = 4'd2,
        SEL_DOUT_CLR  = 4'd3,
        SEL_DIN       = 4'd4,
        SEL_TRIG_LO   = 4'd5,
        SEL_TRIG_HI   = 4'd6,
        SEL_TRIG_RISE = 4'd7,
        SEL_TRIG_FALL = 4'd8,
        SEL_STATUS    = 4'd9,
        SEL_EN_SET    = 4'd10,
        SEL_EN_CLR    = 4'd11,
        SEL_NONE      = 4'd15
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur_q,
    output logic [W-1:0] prev_q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] trig_lo,
    input  logic [W-1:0] trig_hi,
    input  logic [W-1:0] trig_rise,
    input  logic [W-1:0] trig_fall,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status_q
);

    logic [W-1:0] hit;
    logic [W-1:0] drop;

    always_comb begin
        hit  = (trig_lo & ~cur) | (trig_hi & cur)
             | (trig_rise & cur & ~prev) | (trig_fall & ~cur & prev);
        drop = clr_en ? clr_mask : '0;
    end

    // New hits are ORed after the clear so they win a same-cycle race.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~drop) | hit;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((status_q & $past(status_q)) == $past(status_q))); // R7

    AST_LEVEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (((trig_lo & ~cur) | (trig_hi & cur)) != '0)
        |=> ((status_q & $past((trig_lo & ~cur) | (trig_hi & cur)))
             == $past((trig_lo & ~cur) | (trig_hi & cur)))); // R5

    AST_RISE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_rise & cur & ~prev) != '0)
        |=> ((status_q & $past(trig_rise & cur & ~prev))
             == $past(trig_rise & cur & ~prev))); // R6

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  status,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  dout_q,
    output logic [W-1:0]  lo_q,
    output logic [W-1:0]  hi_q,
    output logic [W-1:0]  rise_q,
    output logic [W-1:0]  fall_q,
    output logic [W-1:0]  en_q,
    output logic          stat_clr_en,
    output logic [W-1:0]  stat_clr_mask
);

    localparam int IDX_W = AW - 2;

    reg_sel_e         sel;
    logic [IDX_W-1:0] widx;

    always_comb begin
        widx = addr[AW-1:2];
        sel  = SEL_NONE;
        if (addr[1:0] == 2'b00 && widx < IDX_W'(NUM_REGS))
            sel = reg_sel_e'(widx[SEL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            dout_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DIR:       dir_q  <= wdata;
                SEL_DOUT:      dout_q <= wdata;
                SEL_DOUT_SET:  dout_q <= dout_q | wdata;
                SEL_DOUT_CLR:  dout_q <= dout_q & ~wdata;
                SEL_TRIG_LO:   lo_q   <= wdata;
                SEL_TRIG_HI:   hi_q   <= wdata;
                SEL_TRIG_RISE: rise_q <= wdata;
                SEL_TRIG_FALL: fall_q <= wdata;
                SEL_EN_SET:    en_q   <= en_q | wdata;
                SEL_EN_CLR:    en_q   <= en_q & ~wdata;
                default:       ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:                rdata = dir_q;
            SEL_DOUT:               rdata = dout_q;
            SEL_DIN:                rdata = din;
            SEL_TRIG_LO:            rdata = lo_q;
            SEL_TRIG_HI:            rdata = hi_q;
            SEL_TRIG_RISE:          rdata = rise_q;
            SEL_TRIG_FALL:          rdata = fall_q;
            SEL_STATUS:             rdata = status;
            SEL_EN_SET, SEL_EN_CLR: rdata = en_q;
            default:                rdata = '0;
        endcase
        stat_clr_en   = wr_en && (sel == SEL_STATUS);
        stat_clr_mask = wdata;
    end

    AST_DOUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DOUT_CLR) |=> ((dout_q & $past(wdata)) == '0)); // R3

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata))); // R8

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_drive_en,
    output logic              irq
);

    logic [NPINS-1:0] cur, prev, status;
    logic [NPINS-1:0] dir, dout, lo, hi, rise, fall, en, clr_mask;
    logic             clr_en;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .cur_q(cur), .prev_q(prev)
    );

    gpio_ctrl_regs #(.W(NPINS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .din(cur), .status(status), .rdata(bus_rdata),
        .dir_q(dir), .dout_q(dout), .lo_q(lo), .hi_q(hi), .rise_q(rise),
        .fall_q(fall), .en_q(en), .stat_clr_en(clr_en), .stat_clr_mask(clr_mask)
    );

    gpio_event_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
        .trig_lo(lo), .trig_hi(hi), .trig_rise(rise), .trig_fall(fall),
        .clr_en(clr_en), .clr_mask(clr_mask), .status_q(status)
    );

    always_comb begin
        pin_out      = dout;
        pin_drive_en = ~dir;
        irq          = |(status & en);
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R9

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

    localparam logic [7:0] A_DIR = 8'h00, A_DOUT = 8'h04, A_DSET = 8'h08, A_DCLR = 8'h0C,
                           A_DIN = 8'h10, A_LO = 8'h14, A_HI = 8'h18, A_RISE = 8'h1C,
                           A_FALL = 8'h20, A_STAT = 8'h24, A_ESET = 8'h28, A_ECLR = 8'h2C;

    logic        clk = 0, rst_n = 0, bus_wr_en = 0, irq;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_drive_en;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive_en(pin_drive_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr_en = 1;
        @(negedge clk); bus_wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk); pin_in = v;
    endtask

    function automatic logic [31:0] exp_stat(input logic [31:0] lo, hi, ri, fa, a, b);
        return (lo & ~a) | (hi & a) | (lo & ~b) | (hi & b) | (ri & ~a & b) | (fa & a & ~b);
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_DIR, d);  check("R1 dir", d, 32'hFFFF_FFFF);
        rd(A_DOUT, d); check("R1 dout", d, 0);
        rd(A_LO, d);   check("R1 lo", d, 0);
        rd(A_FALL, d); check("R1 fall", d, 0);
        rd(A_STAT, d); check("R1 stat", d, 0);
        rd(A_ESET, d); check("R1 en", d, 0);
        check("R1 irq/drive", {pin_drive_en[30:0], irq}, 0);
        // R2 direction and output
        wr(A_DIR, 32'h0000_FFFF);
        check("R2 drive_en", pin_drive_en, 32'hFFFF_0000);
        wr(A_DOUT, 32'hA5A5_A5A5);
        check("R2 pin_out", pin_out, 32'hA5A5_A5A5);
        // R3 set/clear
        wr(A_DSET, 32'h0000_000F);
        rd(A_DOUT, d); check("R3 set", d, 32'hA5A5_A5AF);
        wr(A_DCLR, 32'hF000_0001);
        rd(A_DOUT, d); check("R3 clr", d, 32'h05A5_A5AE);
        check("R3 pin_out", pin_out, 32'h05A5_A5AE);
        // R4 synchronizer latency
        @(negedge clk); pin_in = 32'h1234_5678; bus_addr = A_DIN;
        @(negedge clk); #1 check("R4 one edge", bus_rdata, 0);
        @(negedge clk); #1 check("R4 two edges", bus_rdata, 32'h1234_5678);
        // R5 both levels = permanent
        pins(0); repeat (4) @(negedge clk);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_LO, 32'h8); wr(A_HI, 32'h8);
        wr(A_STAT, 32'h8);
        rd(A_STAT, d); check("R5 both low", d, 32'h8);
        pins(32'h8); repeat (4) @(negedge clk);
        wr(A_STAT, 32'h8);
        rd(A_STAT, d); check("R5 both high", d, 32'h8);
        wr(A_LO, 0); wr(A_HI, 0); wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); check("R7 cleared", d, 0);
        // R7 clear vs new hit, and plain clear
        wr(A_HI, 32'h1); wr(A_RISE, 32'h2);
        pins(32'h3); repeat (4) @(negedge clk);
        rd(A_STAT, d); check("R6 rise", d, 32'h3);
        wr(A_STAT, 32'h3);
        rd(A_STAT, d); check("R7 race keeps hit", d, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_STAT, d); check("R7 sticky", d, 32'h1);
        // R9/R8 enables
        check("R9 disabled", {31'd0, irq}, 0);
        wr(A_ESET, 32'h1);
        check("R9 enabled", {31'd0, irq}, 1);
        wr(A_ESET, 32'h100);
        rd(A_ECLR, d); check("R8 read at clear", d, 32'h101);
        wr(A_ECLR, 32'h1);
        rd(A_ESET, d); check("R8 read at set", d, 32'h100);
        check("R9 irq off", {31'd0, irq}, 0);
        // R10 unmapped / data-in write
        rd(8'h30, d); check("R10 unmapped", d, 0);
        rd(8'h05, d); check("R10 unaligned", d, 0);
        wr(8'h30, 32'hFFFF_FFFF); wr(8'h01, 32'h0);
        rd(A_DOUT, d); check("R10 dout kept", d, 32'h05A5_A5AE);
        wr(A_DIN, 32'hDEAD_BEEF);
        rd(A_DIN, d); check("R10 din", d, 32'h3);
        // R5/R6 random trials
        for (int t = 0; t < 40; t++) begin
            logic [31:0] lo, hi, ri, fa, en, a, b, e;
            lo = $urandom & $urandom; hi = $urandom & $urandom;
            ri = $urandom; fa = $urandom; en = $urandom;
            a = $urandom; b = $urandom;
            if (t == 0) begin ri = 32'hFFFF_FFFF; fa = 32'hFFFF_FFFF; lo = 0; hi = 0; end
            wr(A_LO, lo); wr(A_HI, hi); wr(A_RISE, ri); wr(A_FALL, fa);
            wr(A_ECLR, 32'hFFFF_FFFF); wr(A_ESET, en);
            pins(a); repeat (4) @(negedge clk);
            wr(A_STAT, 32'hFFFF_FFFF);
            pins(b); repeat (4) @(negedge clk);
            e = exp_stat(lo, hi, ri, fa, a, b);
            rd(A_STAT, d); check("R5 R6 random status", d, e);
            check("R9 random irq", {31'd0, irq}, {31'd0, |(e & en)});
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule